// File: doc/BRIEF.md
# Bitstream Bit-Window Extractor

This block sits between a word-wide FIFO holding a compressed elementary stream and a variable-length decoder that needs bit-granular access to that stream. It fetches 64-bit words through a read-enable/read-valid handshake. It keeps them in an internal shift buffer and shows the decoder a 24-bit window. The oldest unconsumed stream bit is the window's most significant bit.

Each cycle the decoder may consume 0 to 24 bits, or issue an align command. The align command moves to the next byte boundary and then skips one further byte. A sign output gives the stream bit that follows the bits being consumed in the current cycle. This lets a coefficient's code and its sign be taken in a single cycle. A valid flag tells the decoder when the full window holds real stream data.

Top module: `bitwin_extract`

## Requirements
- R1: While the synchronous active-low reset is applied, the buffer empties: the cycle after a reset edge shows `win_valid` low and `win_bits` all zero, and `fifo_rd_en` stays low during reset.
- R2: `fifo_rd_en` is high for exactly one cycle when no read is outstanding and 64 or fewer bits are buffered. No further read is requested until the matching `fifo_rd_valid` returns.
- R3: Stream order is preserved: word bit 63 enters the stream first, and `win_bits[23]` is the oldest unconsumed bit, followed by younger bits down to `win_bits[0]`.
- R4: With `win_valid` high and `adv_align` low, the window moves forward by exactly `adv_bits` bits (0 to 24) at the next clock edge; 0 leaves it unchanged.
- R5: While `win_valid` is high and `adv_align` is low, `win_sign` equals the stream bit at offset `adv_bits` from the window start, which is the bit just after the consumed code.
- R6: An align command with `win_valid` high skips 8 bits when the consumed-bit total is a multiple of 8, and otherwise skips 16 minus (total mod 8) bits.
- R7: When `adv_align` and a nonzero `adv_bits` arrive together, the align command wins and `adv_bits` is not applied.
- R8: `win_valid` is high exactly when at least 24 bits are buffered. While it is low, advance and align commands change neither the stream position nor the buffered bits.
- R9: The buffer holds 128 bits and never overflows. A `fifo_rd_valid` pulse with no read outstanding is ignored and adds no data.
- R10: A consume that leaves fewer than 24 buffered bits drops `win_valid` in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_rd_en | output | 1 | One-cycle read request to the upstream word FIFO |
| fifo_rd_valid | input | 1 | Marks `fifo_rd_data` as the answer to the outstanding read |
| fifo_rd_data | input | 64 | Stream word, bit 63 first in stream order |
| adv_bits | input | 5 | Number of bits to consume this cycle (0 to 24) |
| adv_align | input | 1 | Skip to the next byte boundary plus one byte |
| win_bits | output | 24 | Left-aligned window of the next unconsumed stream bits |
| win_sign | output | 1 | Stream bit following the bits consumed this cycle |
| win_valid | output | 1 | All 24 window bits hold real stream data |

## Verification
On every cycle, the checks watch several things. The window shifts by the requested count, and a zero advance holds it still. The sign bit reappears as the next window's top bit. The window is frozen while invalid with no data arriving. Read requests never come in back-to-back cycles, and the fill count stays within the buffer.

Some behaviours can only be shown by the bench scenarios against a bit-exact model of the stream. These are the skip length of align at all eight byte phases, the priority of align over advance, and the refill threshold. The others are the rejection of stray read-valid pulses, and the starved case where the window goes invalid and commands have to be ignored.

// File: rtl/bitwin_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the bit-window extractor.
// Assumes the stream starts on a byte boundary after reset.
package bitwin_pkg;

    // What the consume logic does in a given cycle.
    typedef enum logic [1:0] {
        BW_HOLD    = 2'd0,
        BW_ADVANCE = 2'd1,
        BW_ALIGN   = 2'd2
    } bw_cmd_e;

    // Bits to skip for an align: up to the next byte boundary, then one byte more.
    function automatic logic [4:0] bw_align_skip(input logic [2:0] phase);
        if (phase == 3'd0) begin
            return 5'd8;
        end
        return 5'd16 - {2'b00, phase};
    endfunction

endpackage

// File: rtl/bitwin_cmd.sv
`timescale 1ns/1ps
// Command decoder: turns advance/align requests into a shift amount.
// It tracks the consumed-bit phase modulo 8 for byte alignment.
// Assumes ADV_W >= 5 so that an align skip (max 15) fits, and that
// commands are only honoured while the window is valid.
module bitwin_cmd
    import bitwin_pkg::*;
#(
    parameter int ADV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  logic [ADV_W-1:0] adv_bits,
    input  logic             adv_align,
    output logic [ADV_W-1:0] shift_amt
);

    bw_cmd_e    cmd;
    logic [2:0] phase_q;

    // Pick the command: nothing while invalid, align has priority over advance.
    always_comb begin
        if (!win_valid) begin
            cmd = BW_HOLD;
        end else if (adv_align) begin
            cmd = BW_ALIGN;
        end else begin
            cmd = BW_ADVANCE;
        end
    end

    // Translate the command into the number of bits to drop.
    always_comb begin
        case (cmd)
            BW_ADVANCE: shift_amt = adv_bits;
            BW_ALIGN:   shift_amt = ADV_W'(bw_align_skip(phase_q));
            default:    shift_amt = '0;
        endcase
    end

    // Keep the byte phase of the consumed position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 3'd0;
        end else begin
            phase_q <= phase_q + shift_amt[2:0];
        end
    end

endmodule

// File: rtl/bitwin_fetch.sv
`timescale 1ns/1ps
// Refill controller: requests one FIFO word when the fill drops to
// REFILL_AT bits or less and no read is pending. Only the answer to a
// pending read is accepted. Assumes every request is answered eventually.
module bitwin_fetch #(
    parameter int CNT_W     = 8,
    parameter int REFILL_AT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] buf_cnt,
    input  logic             rd_valid,
    output logic             rd_en,
    output logic             take_word
);

    logic pend_q;

    // Issue a request when room for a full word is guaranteed.
    always_comb begin
        rd_en     = rst_n && !pend_q && (buf_cnt <= CNT_W'(REFILL_AT));
        take_word = rd_valid && pend_q;
    end

    // Track the single outstanding read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (rd_en) begin
            pend_q <= 1'b1;
        end else if (take_word) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bitwin_store.sv
`timescale 1ns/1ps
// Left-aligned shift buffer holding the unconsumed stream bits.
// The oldest bit is at the MSB, and bits beyond the fill count are always zero.
// New words are appended directly behind the kept bits.
// Assumes the shift never exceeds the fill count, and that a word only
// arrives when at least WORD_W bits are free after the shift.
module bitwin_store #(
    parameter int WORD_W = 64,
    parameter int WIN_W  = 24,
    parameter int BUF_W  = 128,
    parameter int ADV_W  = 5,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADV_W-1:0]  shift_amt,
    input  logic              take_word,
    input  logic [WORD_W-1:0] word_in,
    input  logic [ADV_W-1:0]  peek_bits,
    output logic [WIN_W-1:0]  win_bits,
    output logic              win_sign,
    output logic              win_valid,
    output logic [CNT_W-1:0]  buf_cnt
);

    localparam int PAD_W = BUF_W - WORD_W;
    localparam int IDX_W = $clog2(BUF_W);

    logic [BUF_W-1:0] buf_q, buf_d, kept, placed;
    logic [CNT_W-1:0] cnt_q, cnt_d, left;
    logic [IDX_W-1:0] sign_idx;

    // Drop consumed bits, then append an accepted word behind what is left.
    always_comb begin
        kept   = buf_q << shift_amt;
        left   = cnt_q - CNT_W'(shift_amt);
        placed = {word_in, {PAD_W{1'b0}}} >> left;
        if (take_word) begin
            buf_d = kept | placed;
            cnt_d = left + CNT_W'(WORD_W);
        end else begin
            buf_d = kept;
            cnt_d = left;
        end
    end

    // Hold the buffer and its fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else begin
            buf_q <= buf_d;
            cnt_q <= cnt_d;
        end
    end

    // Present the window, the sign bit after the requested code, and validity.
    always_comb begin
        sign_idx  = IDX_W'(BUF_W - 1) - IDX_W'(peek_bits);
        win_bits  = buf_q[BUF_W-1 -: WIN_W];
        win_sign  = buf_q[sign_idx];
        win_valid = (cnt_q >= CNT_W'(WIN_W));
        buf_cnt   = cnt_q;
    end

endmodule

// File: rtl/bitwin_extract.sv
`timescale 1ns/1ps
// Bit-window extractor top.
// It feeds a variable-length decoder a 24-bit left-aligned view of a stream
// that arrives as 64-bit FIFO words. The buffer is twice the word width, so a
// refill issued at half fill always fits, even with consumption
// stalled while the read is pending.
module bitwin_extract #(
    parameter int WORD_W = 64,
    parameter int WIN_W  = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic                       fifo_rd_en,
    input  logic                       fifo_rd_valid,
    input  logic [WORD_W-1:0]          fifo_rd_data,
    input  logic [$clog2(WIN_W+1)-1:0] adv_bits,
    input  logic                       adv_align,
    output logic [WIN_W-1:0]           win_bits,
    output logic                       win_sign,
    output logic                       win_valid
);

    localparam int BUF_W     = 2 * WORD_W;
    localparam int CNT_W     = $clog2(BUF_W + 1);
    localparam int ADV_W     = $clog2(WIN_W + 1);
    localparam int REFILL_AT = BUF_W - WORD_W;

    logic [ADV_W-1:0] shift_amt;
    logic [CNT_W-1:0] buf_cnt;
    logic             take_word;

    bitwin_cmd #(
        .ADV_W (ADV_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .adv_bits  (adv_bits),
        .adv_align (adv_align),
        .shift_amt (shift_amt)
    );

    bitwin_fetch #(
        .CNT_W     (CNT_W),
        .REFILL_AT (REFILL_AT)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_cnt   (buf_cnt),
        .rd_valid  (fifo_rd_valid),
        .rd_en     (fifo_rd_en),
        .take_word (take_word)
    );

    bitwin_store #(
        .WORD_W (WORD_W),
        .WIN_W  (WIN_W),
        .BUF_W  (BUF_W),
        .ADV_W  (ADV_W),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_amt (shift_amt),
        .take_word (take_word),
        .word_in   (fifo_rd_data),
        .peek_bits (adv_bits),
        .win_bits  (win_bits),
        .win_sign  (win_sign),
        .win_valid (win_valid),
        .buf_cnt   (buf_cnt)
    );

endmodule

// File: rtl/bitwin_extract_chk.sv
`timescale 1ns/1ps
// Cycle-level checks for bitwin_extract, attached by bind.
module bitwin_extract_chk #(
    parameter int WIN_W = 24,
    parameter int ADV_W = 5,
    parameter int BUF_W = 128,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_rd_en,
    input logic             fifo_rd_valid,
    input logic [ADV_W-1:0] adv_bits,
    input logic             adv_align,
    input logic [WIN_W-1:0] win_bits,
    input logic             win_sign,
    input logic             win_valid,
    input logic [CNT_W-1:0] buf_cnt
);

    // R1: a reset edge leaves an empty, invalid window.
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (!win_valid && win_bits == '0));

    // R2: requests are single pulses while a read is pending.
    p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |=> !fifo_rd_en);

    // R4: the surviving window bits move up by the requested count.
    p_window_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !adv_align) |=>
        (((($past(win_bits) << $past(adv_bits)) ^ win_bits) >> $past(adv_bits)) == '0));

    // R4: a zero advance keeps the window unchanged.
    p_zero_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !adv_align && adv_bits == '0) |=> $stable(win_bits));

    // R5: the sign bit becomes the top bit of the next window.
    p_sign_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !adv_align && adv_bits < ADV_W'(WIN_W)) |=>
        (win_bits[WIN_W-1] == $past(win_sign)));

    // R8: commands are ignored while invalid, so with no data the window is frozen.
    p_invalid_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_valid && !fifo_rd_valid) |=> $stable(win_bits));

    // R9: the fill never exceeds the buffer.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt <= CNT_W'(BUF_W));

endmodule

bind bitwin_extract bitwin_extract_chk #(
    .WIN_W (WIN_W),
    .ADV_W (ADV_W),
    .BUF_W (BUF_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_rd_en    (fifo_rd_en),
    .fifo_rd_valid (fifo_rd_valid),
    .adv_bits      (adv_bits),
    .adv_align     (adv_align),
    .win_bits      (win_bits),
    .win_sign      (win_sign),
    .win_valid     (win_valid),
    .buf_cnt       (buf_cnt)
);

// File: tb/test_bitwin_extract.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task pushes expected windows, and a monitor pops
// and compares them whenever the window is valid. A FIFO model answers
// reads with variable latency and injects stray valid pulses.
module test_bitwin_extract;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_rd_en;
    logic        fifo_rd_valid = 1'b0;
    logic [63:0] fifo_rd_data = '0;
    logic [4:0]  adv_bits = '0;
    logic        adv_align = 1'b0;
    logic [23:0] win_bits;
    logic        win_sign;
    logic        win_valid;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [23:0] win;
        string       tag;
    } item_t;
    item_t sb_q[$];

    int pos = 0;        // consumed bits
    int absorbed = 0;   // words taken in by the design
    int issued = 0;     // words handed out
    bit out = 0;        // read outstanding in the model
    int lat = 0;
    bit real_on = 0, stray_on = 0, hold = 0;
    int last_stray = -1;

    bitwin_extract i_bitwin_extract (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_rd_en    (fifo_rd_en),
        .fifo_rd_valid (fifo_rd_valid),
        .fifo_rd_data  (fifo_rd_data),
        .adv_bits      (adv_bits),
        .adv_align     (adv_align),
        .win_bits      (win_bits),
        .win_sign      (win_sign),
        .win_valid     (win_valid)
    );

    always #10 clk = ~clk;

    function automatic logic [63:0] word_of(int k);
        return {(32'(k) * 32'h9E3779B1) ^ 32'hA5A50F0F, 32'(k + 7) * 32'h85EBCA6B};
    endfunction

    function automatic logic bit_at(longint i);
        logic [63:0] w;
        w = word_of(int'(i / 64));
        return w[63 - int'(i % 64)];
    endfunction

    function automatic logic [23:0] win_at(int p);
        logic [23:0] w;
        for (int b = 0; b < 24; b++) w[23 - b] = bit_at(longint'(p + b));
        return w;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare the window against the scoreboard when valid.
    always @(negedge clk) begin
        if (rst_n && win_valid && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            chk(it.tag, 64'(win_bits), 64'(it.win));
        end
    end

    // FIFO model with request/valid checks (R2, R8, R9).
    always @(negedge clk) begin
        if (rst_n) begin
            int buffered;
            if (real_on) begin
                fifo_rd_valid = 1'b0; real_on = 0; absorbed++; out = 0;
            end
            if (stray_on) begin
                fifo_rd_valid = 1'b0; stray_on = 0;
            end
            buffered = absorbed * 64 - pos;
            chk("R2", 64'(fifo_rd_en), 64'(!out && buffered <= 64));
            chk("R8", 64'(win_valid), 64'(buffered >= 24));
            if (fifo_rd_en) begin
                out = 1; lat = 1 + issued % 3;
            end else if (out && !hold) begin
                lat--;
                if (lat == 0) begin
                    fifo_rd_data = word_of(issued); fifo_rd_valid = 1'b1;
                    issued++; real_on = 1;
                end
            end else if (!out && absorbed % 4 == 1 && last_stray != absorbed) begin
                // R9: stray valid with no read outstanding must be ignored
                fifo_rd_data = ~word_of(issued); fifo_rd_valid = 1'b1;
                stray_on = 1; last_stray = absorbed;
            end
        end
    end

    task automatic wait_valid();
        do begin
            @(negedge clk); #1;
        end while (!win_valid);
    endtask

    // Driver: apply one command and push the expected next window.
    task automatic do_cmd(int adv, bit al, string tag);
        int buffered, step;
        wait_valid();
        adv_bits = 5'(adv); adv_align = al; #1;
        buffered = absorbed * 64 - pos;
        if (!al && buffered > adv)
            chk("R5", 64'(win_sign), 64'(bit_at(longint'(pos + adv))));
        step = al ? ((pos % 8 == 0) ? 8 : 16 - pos % 8) : adv;
        pos += step;
        sb_q.push_back('{win_at(pos), tag});
        @(posedge clk); #1;
        adv_bits = '0; adv_align = 1'b0;
    endtask

    // Starve the buffer, check the invalid drop, then check that commands are ignored.
    task automatic drain_and_ignore();
        int buffered;
        hold = 1;
        @(negedge clk); #1;
        while (win_valid) begin
            adv_bits = 5'd20; pos += 20;
            sb_q.push_back('{win_at(pos), "R10"});
            @(posedge clk); #1;
            adv_bits = '0;
            @(negedge clk); #1;
            chk("R10", 64'(win_valid), 64'((absorbed * 64 - pos) >= 24));
        end
        buffered = absorbed * 64 - pos;
        for (int k = 0; k < 3; k++) begin
            adv_bits = 5'd9; adv_align = (k == 1);
            @(posedge clk); #1;
            @(negedge clk); #1;
            chk("R8", 64'(win_valid), 64'(0));
            if (buffered > 0)
                chk("R8", 64'(win_bits >> (24 - buffered)),
                    64'(win_at(pos) >> (24 - buffered)));
        end
        adv_bits = '0; adv_align = 1'b0;
        if (sb_q.size() > 0) sb_q[sb_q.size() - 1].tag = "R8";
        hold = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", 64'(win_valid), 64'(0));
        chk("R1", 64'(win_bits), 64'(0));
        chk("R1", 64'(fifo_rd_en), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        sb_q.push_back('{win_at(0), "R3"});
        for (int i = 0; i < 60; i++) do_cmd(i % 25, 1'b0, "R4");
        for (int ph = 0; ph < 8; ph++) begin
            int a;
            a = (ph - pos % 8 + 8) % 8;
            if (a != 0) do_cmd(a, 1'b0, "R4");
            do_cmd(0, 1'b1, "R6");
        end
        for (int k = 0; k < 4; k++) begin
            do_cmd(1 + 2 * k, 1'b0, "R4");
            do_cmd(3 + 5 * k, 1'b1, "R7");
        end
        for (int i = 0; i < 20; i++) do_cmd(24, 1'b0, "R9");
        drain_and_ignore();
        for (int i = 0; i < 12; i++) do_cmd((i * 7) % 25, (i % 5 == 4), "R3");
        wait_valid();
        @(negedge clk);
        finish_run();
    end

endmodule